// File: doc/BRIEF.md
# Privileged CSR File Access Controller

This block holds the control and status registers of a single 32-bit hart that runs in machine, supervisor and user modes. The execute stage presents one access at a time: a 12-bit register address, an operation (plain write, bit-set, bit-clear or pure read), write data and a flag telling whether the source operand index or immediate was zero. In the same cycle the block returns the old register value, an illegal-instruction flag and a commit flag. The execute stage must wait for the commit flag before it writes the general-purpose destination register. A legal write lands on the next rising clock edge.

The block checks privilege and read-only status directly from address bits. Supervisor status, interrupt-enable and interrupt-pending have no storage of their own: they are masked windows onto the machine registers. The block also provides a free-running cycle counter, a hart ID that always reads zero and a reset-loaded ISA identification word. A side port lets the trap sequencer outside this block log cause, EPC and trap value, and load the status word and privilege level in one cycle.

The access port is a single-cycle request with no ready signal. Every cycle with `acc_valid` high is answered in that same cycle, so the block never applies back-pressure. Side-port and status pins are plain levels.

Top module: `csr_file_ctrl`

## Requirements
- R1: An access is legal only when address bits [9:8] are numerically no greater than the current privilege level (user 0, supervisor 1, machine 3). Otherwise `acc_illegal` is high, `acc_rdata` is zero and no state changes.
- R2: An access that would write is illegal when address bits [11:10] are 2'b11. Operation codes are 0 write, 1 set-bits, 2 clear-bits and 3 read. Code 0 always writes. Codes 1 and 2 write only when `acc_src_zero` is low.
- R3: Address 0x100 reads machine status (0x300) ANDed with 0x000DE162. A write to 0x100 changes only those bits of machine status.
- R4: Addresses 0x104 and 0x144 are windows through mask 0x222 onto 0x304 and 0x344, for both reads and writes.
- R5: A write to machine interrupt delegation (0x303) keeps only the bits in mask 0x666.
- R6: Address 0xF14 always reads zero. Address 0xC00 reads a counter that is zero at reset release and grows by one every clock, so reads in consecutive cycles differ by exactly one.
- R7: After reset the privilege level is machine, 0x301 reads 0x40141101, and every other stored register reads zero.
- R8: Set-bits or clear-bits with `acc_src_zero` high writes nothing and raises no illegal flag on a read-only address. The same holds for operation code 3.
- R9: `acc_illegal` and `acc_commit` are valid in the cycle of the request, and commit is high exactly for legal requests. A legal write is visible to the next access. An illegal request changes no register.
- R10: The stored registers are 0x300-0x305, 0x340-0x344, 0x102, 0x103, 0x105, 0x140-0x143 and 0x180, plus the aliases of R3 and R4 and the read-only 0xC00 and 0xF14. Any other address reads zero, ignores writes and is not illegal when R1 and R2 allow it.
- R11: When `side_we` is high, the next edge loads machine status and the privilege level from the side port. With `side_log` high it also loads cause, EPC and trap value, into the supervisor set (0x142/0x141/0x143) when `side_to_sup` is high and into the machine set (0x342/0x341/0x343) otherwise. The side port wins over an access write to the same register in the same cycle.
- R12: Set-bits stores old OR data. Clear-bits stores old AND NOT data. Every legal access returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_op | input | 2 | 0 write, 1 set-bits, 2 clear-bits, 3 read |
| acc_addr | input | 12 | Register address |
| acc_wdata | input | 32 | Write or bit-mask data |
| acc_src_zero | input | 1 | Source index or immediate is zero |
| acc_rdata | output | 32 | Old register value, zero when illegal |
| acc_illegal | output | 1 | Illegal-instruction flag for this request |
| acc_commit | output | 1 | Request is legal; writeback may proceed |
| side_we | input | 1 | Trap sequencer update strobe |
| side_log | input | 1 | Also load cause, EPC and trap value |
| side_to_sup | input | 1 | Log into the supervisor set instead of machine |
| side_cause | input | 32 | Cause value |
| side_epc | input | 32 | Exception PC |
| side_tval | input | 32 | Trap value |
| side_mstatus | input | 32 | New machine status word |
| side_priv | input | 2 | New privilege level |
| cur_priv | output | 2 | Current privilege level |
| cur_mstatus | output | 32 | Current machine status word |

## Verification
A wrong privilege register or a wrong address decode shows up in the same cycle as a wrong `acc_illegal` or `acc_commit`. An address sweep at every privilege level therefore exposes it on the first affected address. A wrong alias mask or merge corrupts stored bits silently, and only the next read of that register or its alias reveals it, one cycle after the write at the earliest. The bench therefore always reads a register back through the other name. A counter fault shows as a difference other than one between back-to-back reads of 0xC00.

// File: rtl/csr_file_pkg.sv
package csr_file_pkg;

  localparam int CSR_ADDR_W = 12;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_READ  = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_BANK  = 2'd1,
    SRC_CYCLE = 2'd2,
    SRC_HART  = 2'd3
  } csr_src_e;

  localparam logic [1:0] LVL_U = 2'd0;
  localparam logic [1:0] LVL_S = 2'd1;
  localparam logic [1:0] LVL_M = 2'd3;

  localparam int NUM_SLOTS = 19;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t SL_MSTATUS  = slot_t'(0);
  localparam slot_t SL_MISA     = slot_t'(1);
  localparam slot_t SL_MEDELEG  = slot_t'(2);
  localparam slot_t SL_MIDELEG  = slot_t'(3);
  localparam slot_t SL_MIE      = slot_t'(4);
  localparam slot_t SL_MTVEC    = slot_t'(5);
  localparam slot_t SL_MSCRATCH = slot_t'(6);
  localparam slot_t SL_MEPC     = slot_t'(7);
  localparam slot_t SL_MCAUSE   = slot_t'(8);
  localparam slot_t SL_MTVAL    = slot_t'(9);
  localparam slot_t SL_MIP      = slot_t'(10);
  localparam slot_t SL_SEDELEG  = slot_t'(11);
  localparam slot_t SL_SIDELEG  = slot_t'(12);
  localparam slot_t SL_STVEC    = slot_t'(13);
  localparam slot_t SL_SSCRATCH = slot_t'(14);
  localparam slot_t SL_SEPC     = slot_t'(15);
  localparam slot_t SL_SCAUSE   = slot_t'(16);
  localparam slot_t SL_STVAL    = slot_t'(17);
  localparam slot_t SL_SATP     = slot_t'(18);

  localparam logic [31:0] SUP_STATUS_MASK = 32'h000D_E162;
  localparam logic [31:0] SUP_INT_MASK    = 32'h0000_0222;
  localparam logic [31:0] DELEG_WR_MASK   = 32'h0000_0666;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_file_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CSR_ADDR_W-1:0] addr,
  input  logic [1:0]            priv,
  output csr_src_e              src,
  output slot_t                 slot,
  output logic [XLEN-1:0]       rd_mask,
  output logic [XLEN-1:0]       wr_mask,
  output logic                  priv_ok,
  output logic                  read_only
);

  localparam logic [XLEN-1:0] M_ALL   = '1;
  localparam logic [XLEN-1:0] M_SSTAT = XLEN'(SUP_STATUS_MASK);
  localparam logic [XLEN-1:0] M_SINT  = XLEN'(SUP_INT_MASK);
  localparam logic [XLEN-1:0] M_DELEG = XLEN'(DELEG_WR_MASK);

  // Level needed for the access sits in bits [9:8]; bits [11:10]
  // equal to 2'b11 mark the address as read-only.
  assign priv_ok   = (addr[9:8] <= priv);
  assign read_only = (addr[11:10] == 2'b11);

  always_comb begin
    src     = SRC_BANK;
    slot    = SL_MSTATUS;
    rd_mask = M_ALL;
    wr_mask = M_ALL;
    case (addr)
      12'h300: slot = SL_MSTATUS;
      12'h100: begin
        slot    = SL_MSTATUS;
        rd_mask = M_SSTAT;
        wr_mask = M_SSTAT;
      end
      12'h301: slot = SL_MISA;
      12'h302: slot = SL_MEDELEG;
      12'h303: begin
        slot    = SL_MIDELEG;
        wr_mask = M_DELEG;
      end
      12'h304: slot = SL_MIE;
      12'h104: begin
        slot    = SL_MIE;
        rd_mask = M_SINT;
        wr_mask = M_SINT;
      end
      12'h305: slot = SL_MTVEC;
      12'h340: slot = SL_MSCRATCH;
      12'h341: slot = SL_MEPC;
      12'h342: slot = SL_MCAUSE;
      12'h343: slot = SL_MTVAL;
      12'h344: slot = SL_MIP;
      12'h144: begin
        slot    = SL_MIP;
        rd_mask = M_SINT;
        wr_mask = M_SINT;
      end
      12'h102: slot = SL_SEDELEG;
      12'h103: slot = SL_SIDELEG;
      12'h105: slot = SL_STVEC;
      12'h140: slot = SL_SSCRATCH;
      12'h141: slot = SL_SEPC;
      12'h142: slot = SL_SCAUSE;
      12'h143: slot = SL_STVAL;
      12'h180: slot = SL_SATP;
      12'hC00: src  = SRC_CYCLE;
      12'hF14: src  = SRC_HART;
      default: src  = SRC_NONE;
    endcase
  end

endmodule

// File: rtl/csr_cycle_count.sv
module csr_cycle_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + W'(1);
  end

endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
  import csr_file_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] MISA_RESET = XLEN'(32'h4014_1101)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  slot_t                           wr_slot,
  input  logic [XLEN-1:0]                 wr_data,
  input  logic                            side_we,
  input  logic                            side_log,
  input  logic                            side_to_sup,
  input  logic [XLEN-1:0]                 side_cause,
  input  logic [XLEN-1:0]                 side_epc,
  input  logic [XLEN-1:0]                 side_tval,
  input  logic [XLEN-1:0]                 side_mstatus,
  input  logic [1:0]                      side_priv,
  output logic [NUM_SLOTS-1:0][XLEN-1:0]  regs,
  output logic [1:0]                      priv
);

  logic [NUM_SLOTS-1:0]            side_hit;
  logic [NUM_SLOTS-1:0][XLEN-1:0]  side_val;

  // Trap-sequencer updates, per slot; these override access writes.
  always_comb begin
    side_hit = '0;
    side_val = '0;
    if (side_we) begin
      side_hit[SL_MSTATUS] = 1'b1;
      side_val[SL_MSTATUS] = side_mstatus;
      if (side_log) begin
        if (side_to_sup) begin
          side_hit[SL_SCAUSE] = 1'b1;
          side_val[SL_SCAUSE] = side_cause;
          side_hit[SL_SEPC]   = 1'b1;
          side_val[SL_SEPC]   = side_epc;
          side_hit[SL_STVAL]  = 1'b1;
          side_val[SL_STVAL]  = side_tval;
        end else begin
          side_hit[SL_MCAUSE] = 1'b1;
          side_val[SL_MCAUSE] = side_cause;
          side_hit[SL_MEPC]   = 1'b1;
          side_val[SL_MEPC]   = side_epc;
          side_hit[SL_MTVAL]  = 1'b1;
          side_val[SL_MTVAL]  = side_tval;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [XLEN-1:0] RST_VAL =
      (i == int'(SL_MISA)) ? MISA_RESET : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs[i] <= RST_VAL;
      else if (side_hit[i])                     regs[i] <= side_val[i];
      else if (wr_en && (wr_slot == slot_t'(i))) regs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       priv <= LVL_M;
    else if (side_we) priv <= side_priv;
  end

endmodule

// File: rtl/csr_file_ctrl.sv
module csr_file_ctrl
  import csr_file_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] MISA_RESET = XLEN'(32'h4014_1101)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [1:0]            acc_op,
  input  logic [CSR_ADDR_W-1:0] acc_addr,
  input  logic [XLEN-1:0]       acc_wdata,
  input  logic                  acc_src_zero,
  output logic [XLEN-1:0]       acc_rdata,
  output logic                  acc_illegal,
  output logic                  acc_commit,
  input  logic                  side_we,
  input  logic                  side_log,
  input  logic                  side_to_sup,
  input  logic [XLEN-1:0]       side_cause,
  input  logic [XLEN-1:0]       side_epc,
  input  logic [XLEN-1:0]       side_tval,
  input  logic [XLEN-1:0]       side_mstatus,
  input  logic [1:0]            side_priv,
  output logic [1:0]            cur_priv,
  output logic [XLEN-1:0]       cur_mstatus
);

  csr_op_e                         op;
  csr_src_e                        src;
  slot_t                           slot;
  logic [XLEN-1:0]                 rd_mask, wr_mask;
  logic                            priv_ok, read_only;
  logic [NUM_SLOTS-1:0][XLEN-1:0]  regs;
  logic [1:0]                      priv;
  logic [XLEN-1:0]                 cyc;
  logic [XLEN-1:0]                 stored, view, next_view, merged;
  logic                            wants_write, illegal, bank_we;

  assign op = csr_op_e'(acc_op);

  csr_addr_decode #(.XLEN(XLEN)) u_dec (
    .addr      (acc_addr),
    .priv      (priv),
    .src       (src),
    .slot      (slot),
    .rd_mask   (rd_mask),
    .wr_mask   (wr_mask),
    .priv_ok   (priv_ok),
    .read_only (read_only)
  );

  csr_cycle_count #(.W(XLEN)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cyc)
  );

  assign stored = regs[slot];

  always_comb begin
    case (src)
      SRC_BANK:  view = stored & rd_mask;
      SRC_CYCLE: view = cyc;
      default:   view = '0;
    endcase
  end

  // Set/clear with a zero source never writes, so a read-only
  // address can be read through them without a trap.
  assign wants_write = (op == OP_WRITE) ||
                       (((op == OP_SET) || (op == OP_CLEAR)) && !acc_src_zero);

  assign illegal = acc_valid && (!priv_ok || (read_only && wants_write));

  always_comb begin
    case (op)
      OP_WRITE: next_view = acc_wdata;
      OP_SET:   next_view = view | acc_wdata;
      OP_CLEAR: next_view = view & ~acc_wdata;
      default:  next_view = view;
    endcase
  end

  // Bits outside the alias window keep their stored value.
  assign merged  = (stored & ~wr_mask) | (next_view & wr_mask);
  assign bank_we = acc_valid && !illegal && wants_write && (src == SRC_BANK);

  csr_reg_bank #(.XLEN(XLEN), .MISA_RESET(MISA_RESET)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (bank_we),
    .wr_slot      (slot),
    .wr_data      (merged),
    .side_we      (side_we),
    .side_log     (side_log),
    .side_to_sup  (side_to_sup),
    .side_cause   (side_cause),
    .side_epc     (side_epc),
    .side_tval    (side_tval),
    .side_mstatus (side_mstatus),
    .side_priv    (side_priv),
    .regs         (regs),
    .priv         (priv)
  );

  assign acc_illegal = illegal;
  assign acc_commit  = acc_valid && !illegal;
  assign acc_rdata   = (acc_valid && !illegal) ? view : '0;
  assign cur_priv    = priv;
  assign cur_mstatus = regs[SL_MSTATUS];

endmodule

// File: rtl/csr_file_ctrl_chk.sv
module csr_file_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [1:0]      acc_op,
  input logic [11:0]     acc_addr,
  input logic            acc_src_zero,
  input logic [XLEN-1:0] acc_rdata,
  input logic            acc_illegal,
  input logic            acc_commit,
  input logic [1:0]      cur_priv
);

  logic legal_cyc_rd;
  assign legal_cyc_rd = acc_valid && !acc_illegal && (acc_addr == 12'hC00);

  p_priv_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_addr[9:8] > cur_priv) |-> acc_illegal && (acc_rdata == '0));

  p_ro_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_addr[11:10] == 2'b11) && (acc_op == 2'd0) |-> acc_illegal && !acc_commit);

  p_sstatus_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_illegal && (acc_addr == 12'h100) |->
      ((acc_rdata & ~XLEN'(32'h000D_E162)) == '0));

  p_sint_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_illegal && ((acc_addr == 12'h104) || (acc_addr == 12'h144)) |->
      ((acc_rdata & ~XLEN'(32'h222)) == '0));

  p_hart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_addr == 12'hF14) |-> (acc_rdata == '0));

  p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    legal_cyc_rd && $past(legal_cyc_rd) |-> (acc_rdata == $past(acc_rdata) + XLEN'(1)));

  p_reset_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cur_priv == 2'd3));

  p_quiet_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_op != 2'd0) && ((acc_op == 2'd3) || acc_src_zero) &&
    (acc_addr[9:8] <= cur_priv) |-> !acc_illegal);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_illegal && !acc_commit);

endmodule

bind csr_file_ctrl csr_file_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_op       (acc_op),
  .acc_addr     (acc_addr),
  .acc_src_zero (acc_src_zero),
  .acc_rdata    (acc_rdata),
  .acc_illegal  (acc_illegal),
  .acc_commit   (acc_commit),
  .cur_priv     (cur_priv)
);

// File: tb/tb_csr_file_ctrl.sv
`timescale 1ns/1ps
module tb_csr_file_ctrl;
  import csr_file_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_op = 2'd3;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_src_zero = 1'b0;
  logic [31:0] acc_rdata;
  logic        acc_illegal, acc_commit;
  logic        side_we = 1'b0, side_log = 1'b0, side_to_sup = 1'b0;
  logic [31:0] side_cause = '0, side_epc = '0, side_tval = '0, side_mstatus = '0;
  logic [1:0]  side_priv = 2'd3;
  logic [1:0]  cur_priv;
  logic [31:0] cur_mstatus;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] cyc_m;
  logic [31:0] g_rd, g_cyc, t0;
  logic        g_ill, g_cm;

  always #5 clk = ~clk;

  // Expected counter per R6: zero at reset release, +1 per clock.
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc_m <= '0;
    else        cyc_m <= cyc_m + 32'd1;

  csr_file_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_src_zero(acc_src_zero),
    .acc_rdata(acc_rdata), .acc_illegal(acc_illegal), .acc_commit(acc_commit),
    .side_we(side_we), .side_log(side_log), .side_to_sup(side_to_sup),
    .side_cause(side_cause), .side_epc(side_epc), .side_tval(side_tval),
    .side_mstatus(side_mstatus), .side_priv(side_priv),
    .cur_priv(cur_priv), .cur_mstatus(cur_mstatus)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [1:0] op, input logic [11:0] a,
                     input logic [31:0] d, input logic z);
    @(negedge clk);
    acc_valid = 1'b1; acc_op = op; acc_addr = a; acc_wdata = d; acc_src_zero = z;
    #1;
    g_rd = acc_rdata; g_ill = acc_illegal; g_cm = acc_commit; g_cyc = cyc_m;
    @(posedge clk);
    #1 acc_valid = 1'b0;
  endtask

  task automatic side(input logic [1:0] pr, input logic [31:0] mst, input logic lg,
                      input logic sup, input logic [31:0] ca, input logic [31:0] ep,
                      input logic [31:0] tv);
    @(negedge clk);
    side_we = 1'b1; side_priv = pr; side_mstatus = mst; side_log = lg;
    side_to_sup = sup; side_cause = ca; side_epc = ep; side_tval = tv;
    @(posedge clk);
    #1 side_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R7 reset level", 32'(cur_priv), 32'd3);
    chk("R7 reset status", cur_mstatus, 32'h0);
    acc(2'd3, 12'h301, 0, 0);
    chk("R7 isa word", g_rd, 32'h4014_1101);

    // R1/R7/R10 sweep: every address at every level, read only.
    for (int p = 0; p < 3; p++) begin
      logic [1:0] pv;
      pv = (p == 2) ? 2'd3 : 2'(p);
      side(pv, 32'h0, 1'b0, 1'b0, 0, 0, 0);
      for (int a = 0; a < 4096; a++) begin
        logic [11:0] ad;
        logic        e_ill;
        logic [31:0] e_rd;
        ad = 12'(a);
        acc(2'd3, ad, 0, 0);
        e_ill = (ad[9:8] > pv);
        e_rd  = e_ill ? 32'h0 : (ad == 12'h301) ? 32'h4014_1101 :
                (ad == 12'hC00) ? g_cyc : 32'h0;
        chk("R1 sweep illegal", 32'(g_ill), 32'(e_ill));
        chk("R10 sweep read", g_rd, e_rd);
        chk("R9 sweep commit", 32'(g_cm), 32'(!e_ill));
      end
    end

    // R6 hart id and counter
    acc(2'd3, 12'hF14, 0, 0);
    chk("R6 hart id", g_rd, 32'h0);
    acc(2'd3, 12'hC00, 0, 0); t0 = g_rd;
    acc(2'd3, 12'hC00, 0, 0);
    chk("R6 counter step", g_rd, t0 + 32'd1);

    // R3 status window
    acc(2'd0, 12'h300, 32'hFFFF_FFFF, 0);
    acc(2'd3, 12'h100, 0, 0);
    chk("R3 window read", g_rd, 32'h000D_E162);
    acc(2'd0, 12'h100, 32'h0, 0);
    acc(2'd3, 12'h300, 0, 0);
    chk("R3 window write", g_rd, ~32'h000D_E162);
    chk("R3 status pin", cur_mstatus, ~32'h000D_E162);

    // R4 interrupt windows
    acc(2'd0, 12'h304, 32'hFFFF_FFFF, 0);
    acc(2'd3, 12'h104, 0, 0);
    chk("R4 enable window", g_rd, 32'h222);
    acc(2'd0, 12'h144, 32'hFFFF_FFFF, 0);
    acc(2'd3, 12'h344, 0, 0);
    chk("R4 pending window", g_rd, 32'h222);

    // R5 delegation mask
    acc(2'd0, 12'h303, 32'hFFFF_FFFF, 0);
    acc(2'd3, 12'h303, 0, 0);
    chk("R5 deleg mask", g_rd, 32'h666);

    // R12 set / clear
    acc(2'd0, 12'h340, 32'hF0F0_0000, 0);
    acc(2'd1, 12'h340, 32'h0000_00FF, 0);
    chk("R12 set returns old", g_rd, 32'hF0F0_0000);
    acc(2'd3, 12'h340, 0, 0);
    chk("R12 set result", g_rd, 32'hF0F0_00FF);
    acc(2'd2, 12'h340, 32'hF000_000F, 0);
    acc(2'd3, 12'h340, 0, 0);
    chk("R12 clear result", g_rd, 32'h00F0_00F0);

    // R8 zero-source set/clear
    acc(2'd2, 12'h340, 32'hFFFF_FFFF, 1);
    chk("R8 clear zero-src legal", 32'(g_ill), 32'd0);
    acc(2'd3, 12'h340, 0, 0);
    chk("R8 clear zero-src no write", g_rd, 32'h00F0_00F0);
    acc(2'd1, 12'hC00, 32'h1, 1);
    chk("R8 set zero-src on ro", 32'(g_ill), 32'd0);
    acc(2'd1, 12'hF14, 32'h1, 0);
    chk("R8 set nonzero on ro", 32'(g_ill), 32'd1);

    // R2 plain write to read-only
    acc(2'd0, 12'hC00, 32'h5, 0);
    chk("R2 ro write illegal", 32'(g_ill), 32'd1);
    chk("R2 ro write no commit", 32'(g_cm), 32'd0);

    // R10 unimplemented writable address
    acc(2'd0, 12'h7C0, 32'h1234_5678, 0);
    chk("R10 unimpl write legal", 32'(g_cm), 32'd1);
    acc(2'd3, 12'h7C0, 0, 0);
    chk("R10 unimpl reads zero", g_rd, 32'h0);

    // R11 side port logging into machine set
    side(2'd1, 32'h0000_1880, 1'b1, 1'b0, 32'h8000_0007, 32'h0000_1234, 32'h55);
    chk("R11 level", 32'(cur_priv), 32'd1);
    chk("R11 status", cur_mstatus, 32'h0000_1880);
    acc(2'd3, 12'h342, 0, 0);
    chk("R1 machine reg at S", 32'(g_ill), 32'd1);
    side(2'd3, 32'h0000_1880, 1'b0, 1'b0, 0, 0, 0);
    acc(2'd3, 12'h342, 0, 0);
    chk("R11 m cause", g_rd, 32'h8000_0007);
    acc(2'd3, 12'h341, 0, 0);
    chk("R11 m epc", g_rd, 32'h0000_1234);
    acc(2'd3, 12'h343, 0, 0);
    chk("R11 m tval", g_rd, 32'h55);
    side(2'd3, 32'h0000_1880, 1'b1, 1'b1, 32'h9, 32'h2000, 32'h0);
    acc(2'd3, 12'h142, 0, 0);
    chk("R11 s cause", g_rd, 32'h9);
    acc(2'd3, 12'h141, 0, 0);
    chk("R11 s epc", g_rd, 32'h2000);
    acc(2'd3, 12'h342, 0, 0);
    chk("R11 m cause kept", g_rd, 32'h8000_0007);

    // R9 illegal write leaves state alone
    side(2'd0, 32'h0000_1880, 1'b0, 1'b0, 0, 0, 0);
    acc(2'd0, 12'h340, 32'h0, 0);
    chk("R9 illegal flag", 32'(g_ill), 32'd1);
    chk("R9 no commit", 32'(g_cm), 32'd0);
    side(2'd3, 32'h0000_1880, 1'b0, 1'b0, 0, 0, 0);
    acc(2'd3, 12'h340, 0, 0);
    chk("R9 state kept", g_rd, 32'h00F0_00F0);

    // R11 side port wins a same-cycle conflict
    @(negedge clk);
    side_we = 1'b1; side_log = 1'b1; side_to_sup = 1'b0; side_priv = 2'd3;
    side_mstatus = 32'h0000_1880; side_cause = 0; side_tval = 0;
    side_epc = 32'h0000_AAAA;
    acc_valid = 1'b1; acc_op = 2'd0; acc_addr = 12'h341;
    acc_wdata = 32'h0000_5555; acc_src_zero = 1'b0;
    #1 chk("R9 conflict commit", 32'(acc_commit), 32'd1);
    @(posedge clk);
    #1 begin side_we = 1'b0; acc_valid = 1'b0; end
    acc(2'd3, 12'h341, 0, 0);
    chk("R11 side wins", g_rd, 32'h0000_AAAA);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule